// File: doc/BRIEF.md
# Processor Interrupt Request Gating

This block decides, from the architectural state of a core, whether a hardware interrupt may be taken. It looks at three control bits in the status word (global enable, exception level, error level), the 8-bit interrupt field of both the status and cause words, a debug-mode flag, a per-thread interrupt-exempt bit, and a configuration bit that selects how the 8-bit fields are compared. It drives two combinational results, "enabled" and "pending", and one registered request that the pipeline samples to start exception entry.

The comparison has two personalities. With the configuration bit clear, each cause bit is one interrupt line and the status bit in the same position is its own mask, so a request exists when any line is both raised and unmasked. With the bit set, an external vectored controller writes an encoded number into the cause field, and the status field holds the current priority level. A request then exists only when the cause number is strictly above the level. Vector computation, exception entry and updates to the cause word belong to other blocks.

Top module: `irq_gate`

## Requirements
- R1: `irq_enabled` is 1 exactly when status bit 0 (global enable) is 1, status bit 1 (exception level) is 0, status bit 2 (error level) is 0, `dbg_mode` is 0 and `thr_exempt` is 0; it is combinational.
- R2: With status bit 1 or status bit 2 set, `irq_enabled` is 0 whatever the other inputs are.
- R3: With `dbg_mode` set, `irq_enabled` is 0.
- R4: With `thr_exempt` set, `irq_enabled` is 0.
- R5: With `ext_vec_mode` = 0, `irq_pending` is 1 exactly when the bitwise AND of cause bits 15:8 and status bits 15:8 is non-zero.
- R6: With `ext_vec_mode` = 1, `irq_pending` is 1 exactly when cause bits 15:8, read as an unsigned number, are strictly greater than status bits 15:8 read the same way; equal values give 0.
- R7: Cause bits outside 15:8, and status bits outside 15:8 and 2:0, have no effect on `irq_enabled` or `irq_pending`.
- R8: `irq_take` is updated on each rising clock edge to the AND of `irq_enabled` and `irq_pending` present before that edge; a clock edge with `rst` high sets it to 0.
- R9: When `irq_enabled` is 0 before a clock edge, `irq_take` is 0 after it, whatever the pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| status_word | input | 32 | Status word: bit 0 global enable, bit 1 exception level, bit 2 error level, bits 15:8 mask or level |
| cause_word | input | 32 | Cause word: bits 15:8 pending lines or encoded vector |
| dbg_mode | input | 1 | Core is in debug mode |
| thr_exempt | input | 1 | Running thread is exempt from interrupts |
| ext_vec_mode | input | 1 | 1: level comparison for an external vectored controller; 0: per-line mask |
| irq_enabled | output | 1 | Interrupts are currently allowed |
| irq_pending | output | 1 | An unmasked or higher-priority request exists |
| irq_take | output | 1 | Registered request to take the interrupt |

## Verification
The two functions that meet in one cycle are the enable gate and the pending detector, both feeding the single request register. The bench holds a qualified request for one cycle and, in the very next cycle, raises a blocking bit such as the exception level while pending stays high, and also asserts reset while enable and pending are both high; the scoreboard expects the request to drop on the following edge in both cases. Level-mode pairs that would flip under a signed compare (0x80 against 0x7F) and equal pairs judge the strict unsigned rule.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Default geometry of the control words
    localparam int WORD_W      = 32;
    localparam int IRQ_FIELD_W = 8;
    localparam int IRQ_LSB     = 8;
    localparam int GIE_POS     = 0;
    localparam int EXL_POS     = 1;
    localparam int ERL_POS     = 2;

    // How the interrupt fields are compared
    typedef enum logic {
        CMP_LINE_MASK = 1'b0,
        CMP_LEVEL     = 1'b1
    } cmp_mode_e;

    // Every input that can veto an interrupt
    typedef struct packed {
        logic gie;
        logic exl;
        logic erl;
        logic dbg;
        logic exempt;
    } gate_bits_t;

    // Combined view of the decision
    typedef struct packed {
        logic enabled;
        logic pending;
    } irq_verdict_t;

    function automatic logic gate_open(input gate_bits_t g);
        return g.gie && !g.exl && !g.erl && !g.dbg && !g.exempt;
    endfunction

endpackage

// File: rtl/irq_field_slice.sv
module irq_field_slice #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 8,
    parameter int LSB     = 8
) (
    input  logic [WORD_W-1:0]  word_in,
    output logic [FIELD_W-1:0] field_out
);
    localparam int MSB = LSB + FIELD_W - 1;

    logic [WORD_W-1:0] unused_word;
    assign unused_word = word_in;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        assign field_out[i] = word_in[LSB + i];
    end

    initial begin
        if (MSB >= WORD_W) $error("field does not fit in word");
    end
endmodule

// File: rtl/irq_enable_eval.sv
module irq_enable_eval
    import irq_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gate_bits_t gate,
    output logic       enabled
);
    always_comb begin
        enabled = gate_open(gate);
    end

    assert_level_bits_block_R2: assert property (
        @(posedge clk) disable iff (rst)
        (gate.exl || gate.erl) |-> !enabled
    );

    assert_debug_blocks_R3: assert property (
        @(posedge clk) disable iff (rst)
        gate.dbg |-> !enabled
    );

    assert_exempt_blocks_R4: assert property (
        @(posedge clk) disable iff (rst)
        gate.exempt |-> !enabled
    );
endmodule

// File: rtl/irq_pending_eval.sv
module irq_pending_eval
    import irq_gate_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  cmp_mode_e          mode,
    input  logic [FIELD_W-1:0] req_field,
    input  logic [FIELD_W-1:0] ctl_field,
    output logic               pending
);
    logic [FIELD_W-1:0] line_hits;
    logic               any_line;
    logic               above_level;

    // One gate per interrupt line
    for (genvar i = 0; i < FIELD_W; i++) begin : g_line
        assign line_hits[i] = req_field[i] & ctl_field[i];
    end

    assign any_line    = |line_hits;
    assign above_level = (req_field > ctl_field);

    always_comb begin
        unique case (mode)
            CMP_LEVEL:     pending = above_level;
            default:       pending = any_line;
        endcase
    end

    assert_equal_level_idle_R6: assert property (
        @(posedge clk) disable iff (rst)
        (mode == CMP_LEVEL && req_field == ctl_field) |-> !pending
    );

    assert_quiet_lines_idle_R5: assert property (
        @(posedge clk) disable iff (rst)
        (mode == CMP_LINE_MASK && req_field == '0) |-> !pending
    );
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
#(
    parameter int DATA_W   = irq_gate_pkg::WORD_W,
    parameter int FIELD_W  = irq_gate_pkg::IRQ_FIELD_W,
    parameter int FIELD_LO = irq_gate_pkg::IRQ_LSB,
    parameter int GIE_BIT  = irq_gate_pkg::GIE_POS,
    parameter int EXL_BIT  = irq_gate_pkg::EXL_POS,
    parameter int ERL_BIT  = irq_gate_pkg::ERL_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] cause_word,
    input  logic              dbg_mode,
    input  logic              thr_exempt,
    input  logic              ext_vec_mode,
    output logic              irq_enabled,
    output logic              irq_pending,
    output logic              irq_take
);
    gate_bits_t         gate;
    cmp_mode_e          mode;
    logic [FIELD_W-1:0] req_field;
    logic [FIELD_W-1:0] ctl_field;
    irq_verdict_t       verdict;
    logic               take_q;

    always_comb begin
        gate.gie    = status_word[GIE_BIT];
        gate.exl    = status_word[EXL_BIT];
        gate.erl    = status_word[ERL_BIT];
        gate.dbg    = dbg_mode;
        gate.exempt = thr_exempt;
        mode        = ext_vec_mode ? CMP_LEVEL : CMP_LINE_MASK;
    end

    irq_field_slice #(
        .WORD_W (DATA_W),
        .FIELD_W(FIELD_W),
        .LSB    (FIELD_LO)
    ) u_cause_slice (
        .word_in  (cause_word),
        .field_out(req_field)
    );

    irq_field_slice #(
        .WORD_W (DATA_W),
        .FIELD_W(FIELD_W),
        .LSB    (FIELD_LO)
    ) u_status_slice (
        .word_in  (status_word),
        .field_out(ctl_field)
    );

    irq_enable_eval u_enable (
        .clk    (clk),
        .rst    (rst),
        .gate   (gate),
        .enabled(verdict.enabled)
    );

    irq_pending_eval #(
        .FIELD_W(FIELD_W)
    ) u_pending (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .req_field(req_field),
        .ctl_field(ctl_field),
        .pending  (verdict.pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
        end else begin
            take_q <= verdict.enabled & verdict.pending;
        end
    end

    assign irq_enabled = verdict.enabled;
    assign irq_pending = verdict.pending;
    assign irq_take    = take_q;

    assert_take_follows_R8: assert property (
        @(posedge clk) disable iff (rst)
        (irq_enabled && irq_pending) |=> irq_take
    );

    assert_reset_clears_R8: assert property (
        @(posedge clk)
        rst |=> !irq_take
    );

    assert_disable_drops_R9: assert property (
        @(posedge clk) disable iff (rst)
        !irq_enabled |=> !irq_take
    );

    assert_no_pending_no_take_R8: assert property (
        @(posedge clk) disable iff (rst)
        !irq_pending |=> !irq_take
    );
endmodule

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] status_word = '0;
    logic [31:0] cause_word = '0;
    logic        dbg_mode = 1'b0;
    logic        thr_exempt = 1'b0;
    logic        ext_vec_mode = 1'b0;
    logic        irq_enabled;
    logic        irq_pending;
    logic        irq_take;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } take_item_t;

    take_item_t sb_q[$];
    take_item_t mon_item;

    always #4 clk = ~clk;

    irq_gate uut (
        .clk         (clk),
        .rst         (rst),
        .status_word (status_word),
        .cause_word  (cause_word),
        .dbg_mode    (dbg_mode),
        .thr_exempt  (thr_exempt),
        .ext_vec_mode(ext_vec_mode),
        .irq_enabled (irq_enabled),
        .irq_pending (irq_pending),
        .irq_take    (irq_take)
    );

    function automatic logic ref_en(logic [31:0] s, logic d, logic x);
        return s[0] && !s[1] && !s[2] && !d && !x;
    endfunction

    function automatic logic ref_pend(logic [31:0] c, logic [31:0] s, logic lvl);
        logic [7:0] cf;
        logic [7:0] sf;
        cf = c[15:8];
        sf = s[15:8];
        if (lvl) return int'(cf) > int'(sf);
        return (cf & sf) != 8'h00;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Driver: apply one input set, check the combinational results,
    // queue the request expected after the next edge
    task automatic step(logic r, logic [31:0] s, logic [31:0] c,
                        logic d, logic x, logic m, string tag);
        take_item_t it;
        logic e;
        logic p;
        @(negedge clk);
        rst          = r;
        status_word  = s;
        cause_word   = c;
        dbg_mode     = d;
        thr_exempt   = x;
        ext_vec_mode = m;
        #1;
        e = ref_en(s, d, x);
        p = ref_pend(c, s, m);
        chk(tag, "irq_enabled", irq_enabled, e);
        chk(tag, "irq_pending", irq_pending, p);
        it.exp = r ? 1'b0 : (e & p);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the registered request after every edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            chk(mon_item.tag, "irq_take", irq_take, mon_item.exp);
        end
    end

    localparam logic [31:0] OPEN = 32'h0000_0001;

    initial begin
        // Reset state (R8)
        step(1'b1, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R8 reset");
        step(1'b1, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R8 reset");

        // Per-line mask mode (R1 R5)
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R1 R5 line hit");
        step(0, OPEN | 32'h0000_FB00, 32'h0000_0400, 0, 0, 0, "R5 line masked");
        step(0, OPEN | 32'h0000_8100, 32'h0000_8000, 0, 0, 0, "R5 top line");
        step(0, 32'h0000_FF00, 32'h0000_FF00, 0, 0, 0, "R1 global off");

        // Vetoes (R2 R3 R4)
        step(0, OPEN | 32'h0000_0402, 32'h0000_0400, 0, 0, 0, "R2 exception level");
        step(0, OPEN | 32'h0000_0404, 32'h0000_0400, 0, 0, 0, "R2 error level");
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 1, 0, 0, "R3 debug");
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 1, 0, "R4 exempt");

        // Level mode (R6)
        step(0, OPEN | 32'h0000_0300, 32'h0000_0500, 0, 0, 1, "R6 above");
        step(0, OPEN | 32'h0000_0500, 32'h0000_0500, 0, 0, 1, "R6 equal");
        step(0, OPEN | 32'h0000_0500, 32'h0000_0300, 0, 0, 1, "R6 below");
        step(0, OPEN | 32'h0000_7F00, 32'h0000_8000, 0, 0, 1, "R6 unsigned");
        step(0, OPEN | 32'h0000_FE00, 32'h0000_FF00, 0, 0, 1, "R6 top");
        step(0, OPEN | 32'h0000_0100, 32'h0000_0200, 0, 0, 1, "R6 mask would miss");

        // Bits outside the fields (R7)
        step(0, OPEN | 32'hFFFF_00F8, 32'hFFFF_00FF, 0, 0, 0, "R7 outside bits");
        step(0, OPEN | 32'hFFFF_00F8, 32'hFFFF_00FF, 0, 0, 1, "R7 outside level");

        // Enable drops while pending stays (R9)
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R9 armed");
        step(0, OPEN | 32'h0000_0402, 32'h0000_0400, 0, 0, 0, "R9 drop");
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R9 rearm");
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 1, 0, 0, "R9 debug drop");

        // Reset collides with a qualified request (R8)
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R8 armed");
        step(1, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R8 mid reset");
        step(0, OPEN | 32'h0000_0400, 32'h0000_0400, 0, 0, 0, "R8 release");

        // Sweep of both comparisons (R5 R6)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b += 5) begin
                step(0, OPEN | (32'(b * 17) << 8), 32'(a * 9) << 8, 0, 0, 0, "R5 sweep");
                step(0, OPEN | (32'(b * 17) << 8), 32'(a * 9) << 8, 0, 0, 1, "R6 sweep");
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule